// File: doc/BRIEF.md
# Two-Wire Serial Slave Control Decoder

This block is the serial front end of a small byte-wide non-volatile memory. It oversamples the clock and data lines of a two-wire bus on the system clock, finds start and stop conditions, shifts bytes in and out, and decodes the first byte after every start as a control byte. That byte carries a function code, a device-select field and a direction bit. The block drives the acknowledge bit and passes word addresses and write data to the memory's write logic through one-cycle strobes. It asks the address pointer for read bytes with a one-cycle request, which also advances the pointer. It can also issue a one-cycle command that sets the protect register.

The bus data line is open-drain, so the block only ever pulls it low. This is modelled by `sda_oe_o`: a 1 means the line is driven low and a 0 means it is released. Two function codes are recognised. One is for ordinary memory access. The other is for the protect-register write, which is write-only.

Top module: `tw_slave_decoder`

## Requirements
- R1: A falling data line while the clock is high is a start. From any state, a start releases the data line and restarts control-byte reception. This also discards a partly received byte and any protect command not yet committed.
- R2: A rising data line while the clock is high is a stop. It returns the block to idle with the data line released. After reset the data line is released and no strobe is active.
- R3: Bits are sampled on the rising clock, most significant bit first. The block changes `sda_oe_o` only while the clock is low, so each bit it sends is stable for the whole high time.
- R4: Control byte layout is bits 7..4 function code, bits 3..1 select, bit 0 direction (1 = read). Code 1010 is memory access. If the select field differs from `sel_pins_i`, or the code is neither 1010 nor 0110, the byte gets no acknowledge. All further bytes are then ignored until the next start or stop.
- R5: After an acknowledged memory-write control byte, the next byte pulses `addr_stb_o` with the byte on `byte_o`. Every later byte pulses `data_stb_o`. Each of these bytes is acknowledged.
- R6: After an acknowledged memory-read control byte, the block sends `rd_data_i` bytes MSB first, with one `rd_req_o` pulse as each byte is loaded. A master acknowledge fetches the next byte. A master no-acknowledge releases the line, and no further request is made.
- R7: Control code 0110 with direction 0 is acknowledged. Later bytes in that transfer are not acknowledged. `prot_set_o` pulses once, right after the stop that ends the transfer, and only if no start came in between.
- R8: Control code 0110 with direction 1 (read) is not acknowledged and issues nothing.
- R9: While `prog_busy_i` is high when a control byte completes, that byte is not acknowledged and the transfer is ignored.
- R10: An acknowledge holds `sda_oe_o` high from the clock fall after the eighth bit until the clock fall after the ninth. It is low during the eighth bit's high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sel_pins_i | input | 3 | Device select levels compared with control-byte bits 3..1 |
| prog_busy_i | input | 1 | High while an internal programming cycle runs |
| rd_data_i | input | 8 | Byte at the current address pointer |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| byte_o | output | 8 | Last received address or data byte |
| addr_stb_o | output | 1 | One-cycle strobe: `byte_o` is a word address |
| data_stb_o | output | 1 | One-cycle strobe: `byte_o` is a write data byte |
| rd_req_o | output | 1 | One-cycle request: `rd_data_i` loaded, advance pointer |
| prot_set_o | output | 1 | One-cycle command to set the protect register |

## Verification
The start detector and the pending protect commit can act on the same transfer. A start must cancel the command, while a stop must fire it. The bench sends the protect control byte and then either a stop or a repeated start followed by a stop, and counts `prot_set_o` pulses at the ports. The same collision is provoked for data bytes by a start after four bits of a write byte. The bench judges it by the absence of any extra `data_stb_o` and by a fresh address strobe from the next transfer.

// File: rtl/tw_dec_pkg.sv
package tw_dec_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX_CTRL,
      ST_RX_ADDR,
      ST_RX_DATA,
      ST_TX_DATA,
      ST_IGNORE
   } tw_state_e;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          FILTER_EN   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s_o,
   output logic sda_s_o,
   output logic start_o,
   output logic stop_o,
   output logic scl_rise_o,
   output logic scl_fall_o
);

   localparam int unsigned TOP = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("tw_line_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
   logic scl_f, sda_f;
   logic scl_d, sda_d;

   // metastability chain, bus idles high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_chain <= '1;
         sda_chain <= '1;
      end else begin
         scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
         sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
      end
   end

   if (FILTER_EN) begin : g_filter
      // accept a new level only after two equal samples
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_f <= 1'b1;
            sda_f <= 1'b1;
         end else begin
            if (scl_chain[TOP] == scl_chain[TOP-1]) scl_f <= scl_chain[TOP];
            if (sda_chain[TOP] == sda_chain[TOP-1]) sda_f <= sda_chain[TOP];
         end
      end
   end else begin : g_direct
      assign scl_f = scl_chain[TOP];
      assign sda_f = sda_chain[TOP];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   assign scl_s_o    = scl_f;
   assign sda_s_o    = sda_f;
   assign scl_rise_o = scl_f & ~scl_d;
   assign scl_fall_o = ~scl_f & scl_d;
   assign start_o    = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_o     = scl_f & scl_d & ~sda_d & sda_f;

endmodule

// File: rtl/tw_shift_reg.sv
module tw_shift_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         shift_i,
   input  logic         fill_i,
   output logic [W-1:0] q_o
);

   if (W < 2) begin : g_bad_w
      $error("tw_shift_reg: W must be at least 2");
   end

   // one left-shifting register serves both directions:
   // receive fills with the sampled bit, transmit fills with ones
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_o <= '0;
      else if (load_i)  q_o <= load_val_i;
      else if (shift_i) q_o <= {q_o[W-2:0], fill_i};
   end

endmodule

// File: rtl/tw_ctrl_fsm.sv
module tw_ctrl_fsm
   import tw_dec_pkg::*;
#(
   parameter int unsigned       BYTE_W    = 8,
   parameter int unsigned       CODE_W    = 4,
   parameter int unsigned       SEL_W     = 3,
   parameter logic [CODE_W-1:0] CODE_MEM  = 4'b1010,
   parameter logic [CODE_W-1:0] CODE_PROT = 4'b0110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic [SEL_W-1:0]  sel_pins_i,
   input  logic              prog_busy_i,
   input  logic [BYTE_W-1:0] rd_data_i,
   input  logic [BYTE_W-1:0] sh_q_i,
   output logic              sh_load_o,
   output logic              sh_shift_o,
   output logic              sh_fill_o,
   output logic              sda_oe_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              addr_stb_o,
   output logic              data_stb_o,
   output logic              rd_req_o,
   output logic              prot_set_o
);

   localparam int unsigned       CNT_W    = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(BYTE_W - 1);

   if (CODE_W + SEL_W + 1 != BYTE_W) begin : g_bad_layout
      $error("tw_ctrl_fsm: code, select and direction must fill one byte");
   end
   if (CODE_MEM == CODE_PROT) begin : g_bad_codes
      $error("tw_ctrl_fsm: function codes must differ");
   end

   tw_state_e        state_q, after_q;
   logic             ack_ph_q, ack_q, mack_q, armed_q, oe_q;
   logic [CNT_W-1:0] cnt_q;
   logic [BYTE_W-1:0] byte_q;
   logic             addr_stb_q, data_stb_q, rd_req_q, prot_set_q;

   // received byte as it stands at the eighth rising clock
   logic [BYTE_W-1:0] rx_byte;
   logic [CODE_W-1:0] code_f;
   logic [SEL_W-1:0]  sel_f;
   logic              rd_f;
   assign rx_byte = {sh_q_i[BYTE_W-2:0], sda_s};
   assign code_f  = rx_byte[BYTE_W-1 -: CODE_W];
   assign sel_f   = rx_byte[SEL_W:1];
   assign rd_f    = rx_byte[0];

   logic is_rx, is_tx, live;
   logic rx_shift, tx_shift, byte_done, ack_enter, ack_leave, tx_load;
   assign is_rx     = state_q inside {ST_RX_CTRL, ST_RX_ADDR, ST_RX_DATA};
   assign is_tx     = (state_q == ST_TX_DATA);
   assign live      = (is_rx | is_tx) & ~start_i & ~stop_i;
   assign rx_shift  = live & ~ack_ph_q & is_rx & scl_rise_i;
   assign byte_done = rx_shift & (cnt_q == CNT_LAST);
   assign tx_shift  = live & ~ack_ph_q & is_tx & scl_fall_i
                    & (cnt_q != '0) & (cnt_q != CNT_FULL);
   assign ack_enter = live & ~ack_ph_q & scl_fall_i & (cnt_q == CNT_FULL);
   assign ack_leave = live & ack_ph_q & scl_fall_i;
   assign tx_load   = ack_leave & (is_rx ? (after_q == ST_TX_DATA) : mack_q);

   // acknowledge decision for the byte completing now
   logic      dec_ack, dec_arm, dec_addr, dec_data;
   tw_state_e dec_next;
   always_comb begin
      dec_ack  = 1'b0;
      dec_arm  = 1'b0;
      dec_addr = 1'b0;
      dec_data = 1'b0;
      dec_next = ST_IGNORE;
      case (state_q)
         ST_RX_CTRL: begin
            if (!prog_busy_i && (sel_f == sel_pins_i)) begin
               if (code_f == CODE_MEM) begin
                  dec_ack  = 1'b1;
                  dec_next = rd_f ? ST_TX_DATA : ST_RX_ADDR;
               end else if (code_f == CODE_PROT && !rd_f) begin
                  dec_ack = 1'b1;
                  dec_arm = 1'b1;
               end
            end
         end
         ST_RX_ADDR: begin
            dec_ack  = 1'b1;
            dec_addr = 1'b1;
            dec_next = ST_RX_DATA;
         end
         ST_RX_DATA: begin
            dec_ack  = 1'b1;
            dec_data = 1'b1;
            dec_next = ST_RX_DATA;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         after_q    <= ST_IDLE;
         ack_ph_q   <= 1'b0;
         ack_q      <= 1'b0;
         mack_q     <= 1'b0;
         armed_q    <= 1'b0;
         oe_q       <= 1'b0;
         cnt_q      <= '0;
         byte_q     <= '0;
         addr_stb_q <= 1'b0;
         data_stb_q <= 1'b0;
         rd_req_q   <= 1'b0;
         prot_set_q <= 1'b0;
      end else begin
         addr_stb_q <= 1'b0;
         data_stb_q <= 1'b0;
         rd_req_q   <= 1'b0;
         prot_set_q <= 1'b0;
         if (start_i) begin
            state_q  <= ST_RX_CTRL;
            ack_ph_q <= 1'b0;
            cnt_q    <= '0;
            oe_q     <= 1'b0;
            armed_q  <= 1'b0;
         end else if (stop_i) begin
            state_q    <= ST_IDLE;
            ack_ph_q   <= 1'b0;
            cnt_q      <= '0;
            oe_q       <= 1'b0;
            armed_q    <= 1'b0;
            prot_set_q <= armed_q;
         end else if (is_rx || is_tx) begin
            if (!ack_ph_q) begin
               if (scl_rise_i) cnt_q <= cnt_q + 1'b1;
               if (byte_done) begin
                  ack_q      <= dec_ack;
                  after_q    <= dec_next;
                  armed_q    <= armed_q | dec_arm;
                  addr_stb_q <= dec_addr;
                  data_stb_q <= dec_data;
                  if (dec_addr || dec_data) byte_q <= rx_byte;
               end
               if (tx_shift) oe_q <= ~sh_q_i[BYTE_W-2];
               if (ack_enter) begin
                  mack_q <= 1'b0;
                  if (is_rx && ack_q) begin
                     ack_ph_q <= 1'b1;
                     oe_q     <= 1'b1;
                  end else if (is_rx) begin
                     state_q <= ST_IGNORE;
                     oe_q    <= 1'b0;
                  end else begin
                     ack_ph_q <= 1'b1;
                     oe_q     <= 1'b0;
                  end
               end
            end else begin
               if (scl_rise_i && is_tx) mack_q <= ~sda_s;
               if (ack_leave) begin
                  ack_ph_q <= 1'b0;
                  cnt_q    <= '0;
                  oe_q     <= 1'b0;
                  if (tx_load) begin
                     state_q  <= ST_TX_DATA;
                     oe_q     <= ~rd_data_i[BYTE_W-1];
                     rd_req_q <= 1'b1;
                  end else if (is_rx) begin
                     state_q <= after_q;
                  end else begin
                     state_q <= ST_IGNORE;
                  end
               end
            end
         end
      end
   end

   assign sh_load_o  = tx_load;
   assign sh_shift_o = rx_shift | tx_shift;
   assign sh_fill_o  = is_rx ? sda_s : 1'b1;
   assign sda_oe_o   = oe_q;
   assign byte_o     = byte_q;
   assign addr_stb_o = addr_stb_q;
   assign data_stb_o = data_stb_q;
   assign rd_req_o   = rd_req_q;
   assign prot_set_o = prot_set_q;

   // R1
   start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (state_q == ST_RX_CTRL && !oe_q && !ack_ph_q));

   // R2
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (state_q == ST_IDLE && !oe_q));

   // R3
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q != $past(oe_q)) |-> !$past(scl_s));

   // R6
   tx_bit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TX_DATA && !ack_ph_q) |-> (oe_q == ~sh_q_i[BYTE_W-1]));

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_stb_q, data_stb_q, rd_req_q, prot_set_q}));

   // R7
   prot_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prot_set_q |-> $past(stop_i));

   // R9
   busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && state_q == ST_RX_CTRL && prog_busy_i) |=> !ack_q);

endmodule

// File: rtl/tw_slave_decoder.sv
module tw_slave_decoder #(
   parameter int unsigned       BYTE_W      = 8,
   parameter int unsigned       CODE_W      = 4,
   parameter int unsigned       SEL_W       = 3,
   parameter logic [CODE_W-1:0] CODE_MEM    = 4'b1010,
   parameter logic [CODE_W-1:0] CODE_PROT   = 4'b0110,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter bit                FILTER_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [SEL_W-1:0]  sel_pins_i,
   input  logic              prog_busy_i,
   input  logic [BYTE_W-1:0] rd_data_i,
   output logic              sda_oe_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              addr_stb_o,
   output logic              data_stb_o,
   output logic              rd_req_o,
   output logic              prot_set_o
);

   if (BYTE_W != CODE_W + SEL_W + 1) begin : g_bad_byte
      $error("tw_slave_decoder: BYTE_W must equal CODE_W + SEL_W + 1");
   end

   logic scl_s, sda_s, start, stop, scl_rise, scl_fall;
   logic sh_load, sh_shift, sh_fill;
   logic [BYTE_W-1:0] sh_q;

   tw_line_sync #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILTER_EN   (FILTER_EN)
   ) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_s_o    (scl_s),
      .sda_s_o    (sda_s),
      .start_o    (start),
      .stop_o     (stop),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall)
   );

   tw_shift_reg #(
      .W (BYTE_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (sh_load),
      .load_val_i (rd_data_i),
      .shift_i    (sh_shift),
      .fill_i     (sh_fill),
      .q_o        (sh_q)
   );

   tw_ctrl_fsm #(
      .BYTE_W    (BYTE_W),
      .CODE_W    (CODE_W),
      .SEL_W     (SEL_W),
      .CODE_MEM  (CODE_MEM),
      .CODE_PROT (CODE_PROT)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_s       (scl_s),
      .sda_s       (sda_s),
      .start_i     (start),
      .stop_i      (stop),
      .scl_rise_i  (scl_rise),
      .scl_fall_i  (scl_fall),
      .sel_pins_i  (sel_pins_i),
      .prog_busy_i (prog_busy_i),
      .rd_data_i   (rd_data_i),
      .sh_q_i      (sh_q),
      .sh_load_o   (sh_load),
      .sh_shift_o  (sh_shift),
      .sh_fill_o   (sh_fill),
      .sda_oe_o    (sda_oe_o),
      .byte_o      (byte_o),
      .addr_stb_o  (addr_stb_o),
      .data_stb_o  (data_stb_o),
      .rd_req_o    (rd_req_o),
      .prot_set_o  (prot_set_o)
   );

endmodule

// File: tb/tw_slave_decoder_tb_top.sv
`timescale 1ns/1ps
module tw_slave_decoder_tb_top;

   localparam int H = 10;
   localparam logic [2:0] SEL = 3'b101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic prog_busy = 1'b0;
   logic [7:0] rd_data;
   logic sda_oe, addr_stb, data_stb, rd_req, prot_set;
   logic [7:0] byte_out;
   logic sda_bus;

   always #10 clk = ~clk;

   assign sda_bus = m_sda & ~sda_oe;

   tw_slave_decoder dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (m_scl),
      .sda_i       (sda_bus),
      .sel_pins_i  (SEL),
      .prog_busy_i (prog_busy),
      .rd_data_i   (rd_data),
      .sda_oe_o    (sda_oe),
      .byte_o      (byte_out),
      .addr_stb_o  (addr_stb),
      .data_stb_o  (data_stb),
      .rd_req_o    (rd_req),
      .prot_set_o  (prot_set)
   );

   int n_cmp = 0, n_bad = 0;
   int n_addr = 0, n_data = 0, n_rd = 0, n_prot = 0;
   logic [7:0] last_addr = 8'h00;
   logic [7:0] data_log [16];
   logic [7:0] ptr = 8'h00;
   int cyc = 0;
   bit done = 1'b0;

   function automatic logic [7:0] mem_at(input logic [7:0] a);
      return 8'(a * 8'd7 + 8'd3);
   endfunction

   assign rd_data = mem_at(ptr);

   // monitor of strobes and pointer model
   always @(negedge clk) begin
      if (rst_n) begin
         if (addr_stb) begin n_addr++; last_addr = byte_out; ptr = byte_out; end
         if (data_stb) begin data_log[n_data % 16] = byte_out; n_data++; end
         if (rd_req)   begin n_rd++; ptr = ptr + 8'd1; end
         if (prot_set) n_prot++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_h();
      repeat (H) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wait_h();
      m_scl = 1'b1; wait_h();
      m_sda = 1'b0; wait_h();
      m_scl = 1'b0; wait_h();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wait_h();
      m_scl = 1'b1; wait_h();
      m_sda = 1'b1; wait_h();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; wait_h();
         m_scl = 1'b1; wait_h();
         m_scl = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic got_ack, output logic pre_oe);
      pre_oe = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wait_h();
         m_scl = 1'b1;
         repeat (H/2) @(negedge clk);
         if (i == 0) pre_oe = sda_oe;
         repeat (H - H/2) @(negedge clk);
         m_scl = 1'b0;
      end
      m_sda = 1'b1; wait_h();
      m_scl = 1'b1;
      repeat (H/2) @(negedge clk);
      got_ack = ~sda_bus;
      repeat (H - H/2) @(negedge clk);
      m_scl = 1'b0;
   endtask

   task automatic recv_byte(input logic m_ack, output logic [7:0] b, output logic stable);
      logic s1;
      stable = 1'b1;
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wait_h();
         m_scl = 1'b1;
         repeat (2) @(negedge clk);
         s1 = sda_bus;
         repeat (H - 2) @(negedge clk);
         b[i] = sda_bus;
         if (s1 != sda_bus) stable = 1'b0;
         m_scl = 1'b0;
      end
      m_sda = m_ack ? 1'b0 : 1'b1;
      wait_h();
      m_scl = 1'b1; wait_h();
      m_scl = 1'b0;
   endtask

   task automatic t_reset();
      chk("R2 oe after reset", sda_oe, 0);
      chk("R2 strobes after reset", {addr_stb, data_stb, rd_req, prot_set}, 0);
   endtask

   task automatic t_write();
      logic a, p;
      bus_start();
      send_byte({4'b1010, SEL, 1'b0}, a, p);
      chk("R4 memory write control ack", a, 1);
      chk("R10 no drive during bit 8", p, 0);
      send_byte(8'h3C, a, p);
      chk("R5 address ack", a, 1);
      send_byte(8'hA5, a, p);
      chk("R5 data ack 1", a, 1);
      send_byte(8'h5A, a, p);
      chk("R5 data ack 2", a, 1);
      bus_stop();
      chk("R5 address strobe count", n_addr, 1);
      chk("R5 address value", last_addr, 8'h3C);
      chk("R5 data strobe count", n_data, 2);
      chk("R5 data byte 0", data_log[0], 8'hA5);
      chk("R5 data byte 1", data_log[1], 8'h5A);
      chk("R2 released after stop", sda_oe, 0);
   endtask

   task automatic t_sel_miss();
      logic a, p;
      int na = n_addr;
      bus_start();
      send_byte({4'b1010, 3'b011, 1'b0}, a, p);
      chk("R4 select mismatch no ack", a, 0);
      send_byte(8'h44, a, p);
      chk("R4 later byte ignored", a, 0);
      bus_stop();
      chk("R4 no address strobe", n_addr, na);
   endtask

   task automatic t_bad_code();
      logic a, p;
      bus_start();
      send_byte({4'b1100, SEL, 1'b0}, a, p);
      chk("R4 unknown code no ack", a, 0);
      bus_stop();
   endtask

   task automatic t_rand_read();
      logic a, p, st;
      logic [7:0] b;
      int nr = n_rd;
      bus_start();
      send_byte({4'b1010, SEL, 1'b0}, a, p);
      send_byte(8'h10, a, p);
      chk("R5 read address ack", a, 1);
      bus_start();
      send_byte({4'b1010, SEL, 1'b1}, a, p);
      chk("R1 restart read control ack", a, 1);
      recv_byte(1'b1, b, st);
      chk("R6 read byte 0", b, mem_at(8'h10));
      chk("R3 bit stable while clock high", st, 1);
      recv_byte(1'b1, b, st);
      chk("R6 read byte 1", b, mem_at(8'h11));
      recv_byte(1'b0, b, st);
      chk("R6 read byte 2", b, mem_at(8'h12));
      chk("R3 bit stable last byte", st, 1);
      wait_h();
      chk("R6 released after master nack", sda_oe, 0);
      chk("R6 read requests", n_rd - nr, 3);
      bus_stop();
      chk("R6 no request after nack", n_rd - nr, 3);
   endtask

   task automatic t_cur_read();
      logic a, p, st;
      logic [7:0] b;
      bus_start();
      send_byte({4'b1010, SEL, 1'b1}, a, p);
      chk("R6 current read ack", a, 1);
      recv_byte(1'b0, b, st);
      chk("R6 current read byte", b, mem_at(8'h13));
      bus_stop();
   endtask

   task automatic t_prot_read();
      logic a, p;
      int np = n_prot;
      bus_start();
      send_byte({4'b0110, SEL, 1'b1}, a, p);
      chk("R8 protect read no ack", a, 0);
      bus_stop();
      wait_h();
      chk("R8 no protect command", n_prot, np);
   endtask

   task automatic t_prot_write();
      logic a, p;
      int np = n_prot;
      bus_start();
      send_byte({4'b0110, SEL, 1'b0}, a, p);
      chk("R7 protect write ack", a, 1);
      send_byte(8'h00, a, p);
      chk("R7 following byte no ack", a, 0);
      chk("R7 no command before stop", n_prot, np);
      bus_stop();
      wait_h();
      chk("R7 command after stop", n_prot, np + 1);
   endtask

   task automatic t_prot_abort();
      logic a, p;
      int np = n_prot;
      bus_start();
      send_byte({4'b0110, SEL, 1'b0}, a, p);
      chk("R7 protect ack before restart", a, 1);
      bus_start();
      bus_stop();
      wait_h();
      chk("R1 restart cancels protect", n_prot, np);
   endtask

   task automatic t_busy();
      logic a, p;
      int na = n_addr;
      prog_busy = 1'b1;
      bus_start();
      send_byte({4'b1010, SEL, 1'b0}, a, p);
      chk("R9 busy control no ack", a, 0);
      send_byte(8'h55, a, p);
      chk("R9 busy transfer ignored", a, 0);
      bus_stop();
      chk("R9 no address strobe while busy", n_addr, na);
      prog_busy = 1'b0;
      bus_start();
      send_byte({4'b1010, SEL, 1'b0}, a, p);
      chk("R9 ack once idle", a, 1);
      bus_stop();
   endtask

   task automatic t_mid_start();
      logic a, p;
      int nd;
      bus_start();
      send_byte({4'b1010, SEL, 1'b0}, a, p);
      send_byte(8'h20, a, p);
      nd = n_data;
      send_bits(8'hF0, 4);
      bus_start();
      send_byte({4'b1010, SEL, 1'b0}, a, p);
      chk("R1 control ack after mid-byte start", a, 1);
      send_byte(8'h21, a, p);
      bus_stop();
      chk("R1 partial byte dropped", n_data, nd);
      chk("R1 new address taken", last_addr, 8'h21);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write();
      t_sel_miss();
      t_bad_code();
      t_rand_read();
      t_cur_read();
      t_prot_read();
      t_prot_write();
      t_prot_abort();
      t_busy();
      t_mid_start();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule